// File: doc/BRIEF.md
# Receive Byte Queue with Threshold-Driven RTS

This block is the receive-side byte queue of a serial port. Bytes arriving from the deserializer with a valid strobe are stored in order. Software reads the receive holding location with either a byte access, which removes one byte, or a word access. In multi-data mode a word access removes up to four consecutive bytes at once. In single-data mode, which is used for 9-bit or line-bus framings, a word access still yields one item. A byte that arrives while the queue is full is dropped, and a sticky overrun flag records the loss.

The block can also drive the RTS flow-control line from the queue fill level. Two programmable marks form a hysteresis band. When the fill level falls to or below the low mark, RTS is deasserted so that the far end may transmit. When it climbs to or above the high mark, RTS is asserted so that the far end pauses. Inside the band the line keeps its last level. When automatic control is off, RTS follows a software bit.

Top module: `rxq_rts_fifo`

## Requirements
- R1: After reset, `level` is 0, `rx_ready` is 0, `rts` is 0, `overrun` is 0, and `rd_data` is 0 while no read is requested.
- R2: Bytes leave in arrival order. A byte read (`rd_en`=1, `rd_word`=0) returns the oldest byte in `rd_data[7:0]` with bits 31:8 zero, and lowers `level` by one at the clock edge.
- R3: A word read (`rd_en`=1, `rd_word`=1, `single_mode`=0) with at least four bytes queued returns the oldest byte in bits 7:0, the next in 15:8, then 23:16 and 31:24, and lowers `level` by four.
- R4: A word read with fewer than four bytes queued returns the bytes present in the lowest lanes and zero in the rest, and removes only those bytes. A read of an empty queue returns 0 and leaves `level` at 0.
- R5: With `single_mode`=1, a word read returns only the oldest byte in bits 7:0 (upper bits zero) and lowers `level` by one.
- R6: A byte that arrives while `level` equals DEPTH and no read is removing bytes in the same cycle is dropped and sets `overrun`. If a read removes bytes in that same cycle, the arriving byte is kept.
- R7: `overrun` stays set until `ovr_clr` is pulsed. If a drop and `ovr_clr` occur in the same cycle, `overrun` stays set.
- R8: `level` never exceeds DEPTH, and `rx_ready` is 1 exactly when `level` is nonzero.
- R9: With `fc_auto`=1, a clock edge that moves `level` from above `thr_lo` to at or below `thr_lo` makes `rts` 0 after that edge.
- R10: With `fc_auto`=1, a clock edge that moves `level` from below `thr_hi` to at or above `thr_hi` makes `rts` 1 after that edge.
- R11: With `fc_auto`=1, a clock edge that crosses neither mark leaves `rts` unchanged.
- R12: With `fc_auto`=0, `rts` takes the value `sw_rts` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Strobe: `rx_byte` is valid this cycle |
| rd_en | input | 1 | Read of the holding location this cycle |
| rd_word | input | 1 | 1 = word (32-bit) access, 0 = byte access |
| single_mode | input | 1 | 1 = single-data mode: a word read yields one item |
| fc_auto | input | 1 | 1 = RTS driven by fill-level marks |
| sw_rts | input | 1 | RTS level used when `fc_auto` is 0 |
| thr_lo | input | CW | Low mark (must not exceed `thr_hi`) |
| thr_hi | input | CW | High mark |
| ovr_clr | input | 1 | Pulse that clears `overrun` |
| rd_data | output | 32 | Read data for the current access (combinational) |
| level | output | CW | Number of bytes queued |
| rx_ready | output | 1 | At least one byte is queued |
| rts | output | 1 | Flow-control level: 1 = pause the far end |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
Two functions can fall in the same cycle: an incoming byte and a read that drains the queue. When the queue is full, the outcome decides whether the byte is kept or dropped. The bench fills the queue to DEPTH and then presents a byte together with a byte read in one cycle. It judges the result from an unchanged `level`, a still-set `overrun` (left over from an earlier deliberate drop), and the kept byte appearing last when the queue is drained. The same full state is used to raise a drop and an `ovr_clr` pulse together, and `overrun` is expected to stay set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = LANES * BYTE_W;
   localparam int unsigned POP_W  = $clog2(LANES + 1);
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_req,
   input  byte_t               wr_byte,
   input  logic [POP_W-1:0]    pop_n,
   input  logic                ovr_clr,
   output logic [CW-1:0]       level,
   output logic [CW-1:0]       level_nxt,
   output logic [WORD_W-1:0]   peek,
   output logic                ovr
);
   byte_t            mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    after_pop;
   logic             accept;

   assign after_pop = level - CW'(pop_n);
   assign accept    = wr_req && (after_pop < CW'(DEPTH));
   assign level_nxt = after_pop + CW'(accept);

   for (genvar i = 0; i < LANES; i++) begin : g_peek
      assign peek[i*BYTE_W +: BYTE_W] = mem[rd_ptr + AW'(i)];
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovr    <= 1'b0;
      end else begin
         if (accept) wr_ptr <= wr_ptr + 1'b1;
         rd_ptr <= rd_ptr + AW'(pop_n);
         level  <= level_nxt;
         if (wr_req && !accept) ovr <= 1'b1;
         else if (ovr_clr)      ovr <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (level == CW'(DEPTH) && pop_n == '0 && wr_req) |=> (level == CW'(DEPTH) && ovr)); // R6
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH)); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr); // R7
endmodule

// File: rtl/rxq_rd_pack.sv
module rxq_rd_pack
   import rxq_pkg::*;
#(
   parameter int unsigned CW = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic                rd_word,
   input  logic                single_mode,
   input  logic [CW-1:0]       level,
   input  logic [WORD_W-1:0]   peek,
   output logic [WORD_W-1:0]   rd_data,
   output logic [POP_W-1:0]    pop_n
);
   logic [POP_W-1:0] want;

   always_comb begin
      if (!rd_en)                      want = '0;
      else if (rd_word && !single_mode) want = POP_W'(LANES);
      else                             want = POP_W'(1);
      pop_n = (CW'(want) > level) ? POP_W'(level) : want;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rd_data[i*BYTE_W +: BYTE_W] =
         (POP_W'(i) < pop_n) ? peek[i*BYTE_W +: BYTE_W] : '0;
   end

   AST_POP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= level); // R4
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> (rd_data == '0)); // R4
   AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && single_mode && level != '0) |-> (rd_data[WORD_W-1:BYTE_W] == '0)); // R5
endmodule

// File: rtl/rxq_rts_ctl.sv
module rxq_rts_ctl #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fc_en,
   input  logic          sw_rts,
   input  logic [CW-1:0] lo,
   input  logic [CW-1:0] hi,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] level_nxt,
   output logic          rts
);
   logic rise, fall;

   assign rise = (level < hi) && (level_nxt >= hi);
   assign fall = (level > lo) && (level_nxt <= lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rts <= 1'b0;
      else if (!fc_en) rts <= sw_rts;
      else if (rise)   rts <= 1'b1;
      else if (fall)   rts <= 1'b0;
   end

   AST_RTS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_en && lo <= hi && level > lo && level_nxt <= lo) |=> !rts); // R9
   AST_RTS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_en && lo <= hi && level < hi && level_nxt >= hi) |=> rts); // R10
   AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_en && level > lo && level < hi && level_nxt > lo && level_nxt < hi) |=> $stable(rts)); // R11
   AST_RTS_SW: assert property (@(posedge clk) disable iff (!rst_n)
      !fc_en |=> (rts == $past(sw_rts))); // R12
endmodule

// File: rtl/rxq_rts_fifo.sv
module rxq_rts_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        rx_byte,
   input  logic              rx_valid,
   input  logic              rd_en,
   input  logic              rd_word,
   input  logic              single_mode,
   input  logic              fc_auto,
   input  logic              sw_rts,
   input  logic [CW-1:0]     thr_lo,
   input  logic [CW-1:0]     thr_hi,
   input  logic              ovr_clr,
   output logic [31:0]       rd_data,
   output logic [CW-1:0]     level,
   output logic              rx_ready,
   output logic              rts,
   output logic              overrun
);
   if (DEPTH < LANES) begin : g_bad_depth
      $error("rxq_rts_fifo: DEPTH must be at least the lane count");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("rxq_rts_fifo: DEPTH must be a power of two");
   end

   logic [CW-1:0]     level_nxt;
   logic [WORD_W-1:0] peek;
   logic [POP_W-1:0]  pop_n;

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (rx_valid),
      .wr_byte   (rx_byte),
      .pop_n     (pop_n),
      .ovr_clr   (ovr_clr),
      .level     (level),
      .level_nxt (level_nxt),
      .peek      (peek),
      .ovr       (overrun)
   );

   rxq_rd_pack #(.CW(CW)) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en       (rd_en),
      .rd_word     (rd_word),
      .single_mode (single_mode),
      .level       (level),
      .peek        (peek),
      .rd_data     (rd_data),
      .pop_n       (pop_n)
   );

   rxq_rts_ctl #(.CW(CW)) u_rts (
      .clk       (clk),
      .rst_n     (rst_n),
      .fc_en     (fc_auto),
      .sw_rts    (sw_rts),
      .lo        (thr_lo),
      .hi        (thr_hi),
      .level     (level),
      .level_nxt (level_nxt),
      .rts       (rts)
   );

   assign rx_ready = (level != '0);

   AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (level != '0) |=> (rx_ready || $past(pop_n) != '0)); // R8
endmodule

// File: tb/rxq_rts_fifo_bench.sv
`timescale 1ns/1ps
module rxq_rts_fifo_bench;
   localparam int DEPTH = 16;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] rx_byte = '0;
   logic rx_valid = 0, rd_en = 0, rd_word = 0, single_mode = 0;
   logic fc_auto = 0, sw_rts = 0, ovr_clr = 0;
   logic [CW-1:0] thr_lo = '0, thr_hi = '0;
   logic [31:0] rd_data;
   logic [CW-1:0] level;
   logic rx_ready, rts, overrun;

   int checks = 0;
   int errors = 0;
   logic [31:0] got;

   always #5 clk = ~clk;

   rxq_rts_fifo #(.DEPTH(DEPTH)) u_rxq_rts_fifo (
      .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .rd_en(rd_en), .rd_word(rd_word), .single_mode(single_mode),
      .fc_auto(fc_auto), .sw_rts(sw_rts), .thr_lo(thr_lo), .thr_hi(thr_hi),
      .ovr_clr(ovr_clr), .rd_data(rd_data), .level(level),
      .rx_ready(rx_ready), .rts(rts), .overrun(overrun)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      step();
      rx_valid = 1'b0;
   endtask

   task automatic rd(input logic word, output logic [31:0] d);
      rd_en = 1'b1;
      rd_word = word;
      #1;
      d = rd_data;
      step();
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 level", 32'(level), 0);
      check("R1 rx_ready", 32'(rx_ready), 0);
      check("R1 rts", 32'(rts), 0);
      check("R1 overrun", 32'(overrun), 0);
      check("R1 rd_data", rd_data, 0);
   endtask

   task automatic t_byte_and_short();
      push(8'hA1); push(8'hA2); push(8'hA3);
      rd(1'b0, got);
      check("R2 byte read", got, 32'h0000_00A1);
      check("R2 level after byte read", 32'(level), 2);
      check("R8 rx_ready", 32'(rx_ready), 1);
      rd(1'b1, got);
      check("R4 short word read", got, 32'h0000_A3A2);
      check("R4 level after short read", 32'(level), 0);
      check("R8 rx_ready empty", 32'(rx_ready), 0);
      rd(1'b1, got);
      check("R4 empty read data", got, 0);
      check("R4 empty read level", 32'(level), 0);
   endtask

   task automatic t_word();
      for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
      rd(1'b1, got);
      check("R3 word read", got, 32'h1312_1110);
      check("R3 level after word", 32'(level), 2);
      rd(1'b1, got);
      check("R4 tail word", got, 32'h0000_1514);
   endtask

   task automatic t_single();
      single_mode = 1'b1;
      push(8'h21); push(8'h22); push(8'h23);
      rd(1'b1, got);
      check("R5 single word read", got, 32'h0000_0021);
      check("R5 single level", 32'(level), 2);
      single_mode = 1'b0;
      rd(1'b1, got);
      check("R3 back to multi", got, 32'h0000_2322);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i));
      check("R8 full level", 32'(level), DEPTH);
      push(8'hEE);
      check("R6 dropped level", 32'(level), DEPTH);
      check("R6 overrun set", 32'(overrun), 1);
      rd(1'b0, got);
      check("R6 head intact", got, 32'h0000_0040);
      push(8'h55);
      rx_valid = 1'b1; rx_byte = 8'h66;
      rd(1'b0, got);
      rx_valid = 1'b0;
      check("R6 read+write data", got, 32'h0000_0041);
      check("R6 read+write level", 32'(level), DEPTH);
      check("R7 overrun sticky", 32'(overrun), 1);
      rx_valid = 1'b1; rx_byte = 8'h77; ovr_clr = 1'b1;
      step();
      rx_valid = 1'b0; ovr_clr = 1'b0;
      check("R7 set wins over clear", 32'(overrun), 1);
      ovr_clr = 1'b1;
      step();
      ovr_clr = 1'b0;
      check("R7 cleared", 32'(overrun), 0);
      for (int i = 0; i < 4; i++) rd(1'b1, got);
      check("R6 kept byte last", got, 32'h6655_4F4E);
      check("R6 drained", 32'(level), 0);
   endtask

   task automatic t_rts();
      thr_lo = CW'(4); thr_hi = CW'(10); sw_rts = 1'b0;
      fc_auto = 1'b1;
      for (int i = 0; i < 9; i++) push(8'(i));
      check("R11 below high mark", 32'(rts), 0);
      push(8'h09);
      check("R10 rise at high mark", 32'(rts), 1);
      rd(1'b0, got);
      check("R11 hold inside band", 32'(rts), 1);
      rd(1'b1, got);
      check("R11 hold at 5", 32'(rts), 1);
      rd(1'b0, got);
      check("R9 fall at low mark", 32'(rts), 0);
      push(8'h99);
      check("R11 hold after fall", 32'(rts), 0);
      for (int i = 0; i < 7; i++) push(8'(i));
      check("R10 rise on way to 12", 32'(rts), 1);
      rd(1'b1, got);
      check("R11 hold at 8", 32'(rts), 1);
      rd(1'b1, got);
      check("R9 fall by word read", 32'(rts), 0);
      fc_auto = 1'b0; sw_rts = 1'b1;
      step();
      check("R12 follows sw high", 32'(rts), 1);
      sw_rts = 1'b0;
      step();
      check("R12 follows sw low", 32'(rts), 0);
      rd(1'b1, got);
   endtask

   initial begin
      fork
         begin
            #3;
            t_reset();
            rst_n = 1'b1;
            step();
            t_byte_and_short();
            t_word();
            t_single();
            t_full();
            t_rts();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule